// File: doc/BRIEF.md
# MSI Write-Back Coherence Controller

This block keeps one direct-mapped, write-back cache coherent with its peers on a shared snooping bus using three line states: Modified (dirty, sole valid copy), Shared (clean, memory current, other caches may hold it) and Invalid. Each line holds a tag, a state and a single data word. The processor side issues single-word reads and writes. The controller answers hits locally. On a miss or an ownership change it runs bus transactions: read, read-exclusive, and a writeback when a dirty victim is replaced.

The snoop side watches read and read-exclusive requests from other caches. A hit on a Modified line drives a flush with the line's data in the same cycle. Memory and the requester both take that data. The line state is updated at the following clock edge. Bus commands use the 2-bit code 00 none, 01 read, 10 read-exclusive, 11 writeback. The snoop command input uses 01 read and 10 read-exclusive, and any other code is ignored. An address splits into a tag in the upper bits and a line index in the low IDX_W bits.

The processor holds its request, address and data steady until `cpu_ready_o`. The bus owner completes a transaction by raising `bus_gnt_i` for one cycle, with read data on `bus_rdata_i` in that cycle.

Top module: `msi_wb_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req_o`, `cpu_ready_o` and `snp_flush_o` are low.
- R2: A processor read whose line is not present issues a bus read (code 01). It returns `bus_rdata_i` in the grant cycle, and the line becomes Shared.
- R3: A processor write to a line that is not Modified, whether present as Shared or absent, issues a read-exclusive (code 10). The line becomes Modified and holds the written word.
- R4: Reads that hit a Shared or Modified line, and writes that hit a Modified line, complete with `cpu_ready_o` in the request cycle and no bus request.
- R5: A snooped read (01) that hits a Modified line raises `snp_flush_o` with the line's word on `snp_data_o`, and the line drops to Shared.
- R6: A snooped read that hits a Shared line causes no flush and leaves the line Shared.
- R7: A snooped read-exclusive (10) that hits a Shared line invalidates it without a flush. On a Modified line it flushes the word, then invalidates the line.
- R8: A snoop whose tag differs from the stored tag, or whose command is neither 01 nor 10, causes no flush and leaves the state unchanged.
- R9: A miss whose index holds a Modified line with another tag first issues a writeback (code 11) carrying the old tag's address and word. The read or read-exclusive follows only after that writeback is granted.
- R10: A miss whose index holds a Shared or Invalid line issues no writeback.
- R11: `bus_req_o` is raised only while a processor request is outstanding, and always with a non-zero command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request pending |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address of the request |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read word, valid with ready |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_cmd_o | output | 2 | 01 read, 10 read-exclusive, 11 writeback |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Writeback word |
| bus_gnt_i | input | 1 | Transaction completes this cycle |
| bus_rdata_i | input | DATA_W | Fill word from memory or a peer |
| snp_valid_i | input | 1 | Snooped request present |
| snp_cmd_i | input | 2 | Snooped command: 01 read, 10 read-exclusive |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_flush_o | output | 1 | This cache supplies the data |
| snp_data_o | output | DATA_W | Flushed word |

## Verification
The bench builds the controller with ADDR_W=8, IDX_W=2 and DATA_W=16. That gives four lines, so small addresses such as 0x05 and 0x09 already collide on one index with different tags. This makes dirty-victim writebacks, clean evictions and tag-mismatched snoops easy to reach. The 256-word address space also lets the bench keep a full memory model. Flushes and writebacks update that model, so later misses prove that evicted or flushed data reached memory.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/msi_line_store.sv
`timescale 1ns/1ps
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // processor-side read port
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output line_st_e          cpu_st_o,
  output logic [TAG_W-1:0]  cpu_tag_o,
  output logic [DATA_W-1:0] cpu_data_o,
  // snoop-side read port
  input  logic [IDX_W-1:0]  snp_idx_i,
  output line_st_e          snp_st_o,
  output logic [TAG_W-1:0]  snp_tag_o,
  output logic [DATA_W-1:0] snp_data_o,
  // processor-side update
  input  logic              upd_we_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  line_st_e          upd_st_i,
  input  logic [TAG_W-1:0]  upd_tag_i,
  input  logic              upd_data_we_i,
  input  logic [DATA_W-1:0] upd_data_i,
  // snoop-side state update
  input  logic              snp_we_i,
  input  line_st_e          snp_st_i
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  logic snp_blocked;
  assign snp_blocked = upd_we_i && (upd_idx_i == snp_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (snp_we_i && !snp_blocked) st_q[snp_idx_i] <= snp_st_i;
      if (upd_we_i) begin
        st_q[upd_idx_i]  <= upd_st_i;
        tag_q[upd_idx_i] <= upd_tag_i;
      end
      if (upd_data_we_i) data_q[upd_idx_i] <= upd_data_i;
    end
  end

  assign cpu_st_o   = st_q[cpu_idx_i];
  assign cpu_tag_o  = tag_q[cpu_idx_i];
  assign cpu_data_o = data_q[cpu_idx_i];
  assign snp_st_o   = st_q[snp_idx_i];
  assign snp_tag_o  = tag_q[snp_idx_i];
  assign snp_data_o = data_q[snp_idx_i];

  // R5
  snp_no_grant_m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_we_i |-> snp_st_i != ST_M);
endmodule

// File: rtl/msi_snoop.sv
`timescale 1ns/1ps
module msi_snoop
  import msi_pkg::*;
#(
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              flush_o,
  output logic [DATA_W-1:0] data_o,
  output logic              st_we_o,
  output line_st_e          st_o
);
  logic hit;
  assign hit = snp_valid_i && (line_st_i != ST_I) && (line_tag_i == snp_tag_i);

  always_comb begin
    flush_o = 1'b0;
    st_we_o = 1'b0;
    st_o    = line_st_i;
    if (hit) begin
      unique case (snp_cmd_i)
        CMD_RD: if (line_st_i == ST_M) begin
          flush_o = 1'b1;
          st_we_o = 1'b1;
          st_o    = ST_S;
        end
        CMD_RDX: begin
          flush_o = (line_st_i == ST_M);
          st_we_o = 1'b1;
          st_o    = ST_I;
        end
        default: ;
      endcase
    end
  end

  assign data_o = flush_o ? line_data_i : '0;

  // R6
  shared_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == CMD_RD && line_st_i == ST_S) |-> !flush_o && !st_we_o);
endmodule

// File: rtl/msi_proc_fsm.sv
`timescale 1ns/1ps
module msi_proc_fsm
  import msi_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cpu_req_i,
  input  logic                   cpu_we_i,
  input  logic [TAG_W-1:0]       cpu_tag_i,
  input  logic [IDX_W-1:0]       cpu_idx_i,
  input  logic [DATA_W-1:0]      cpu_wdata_i,
  output logic                   cpu_ready_o,
  output logic [DATA_W-1:0]      cpu_rdata_o,
  input  line_st_e               line_st_i,
  input  logic [TAG_W-1:0]       line_tag_i,
  input  logic [DATA_W-1:0]      line_data_i,
  output logic                   bus_req_o,
  output logic [1:0]             bus_cmd_o,
  output logic [TAG_W+IDX_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0]      bus_wdata_o,
  input  logic                   bus_gnt_i,
  input  logic [DATA_W-1:0]      bus_rdata_i,
  output logic                   upd_we_o,
  output line_st_e               upd_st_o,
  output logic [TAG_W-1:0]       upd_tag_o,
  output logic                   upd_data_we_o,
  output logic [DATA_W-1:0]      upd_data_o
);
  typedef enum logic [1:0] {PS_IDLE, PS_WB, PS_FILL} ps_e;

  ps_e state_q, state_d;
  logic tag_hit, local_ok, victim_dirty;

  assign tag_hit      = (line_st_i != ST_I) && (line_tag_i == cpu_tag_i);
  assign local_ok     = tag_hit && (!cpu_we_i || line_st_i == ST_M);
  assign victim_dirty = (line_st_i == ST_M) && (line_tag_i != cpu_tag_i);

  always_comb begin
    state_d       = state_q;
    cpu_ready_o   = 1'b0;
    cpu_rdata_o   = '0;
    bus_req_o     = 1'b0;
    bus_cmd_o     = CMD_NONE;
    bus_addr_o    = {cpu_tag_i, cpu_idx_i};
    bus_wdata_o   = '0;
    upd_we_o      = 1'b0;
    upd_st_o      = line_st_i;
    upd_tag_o     = cpu_tag_i;
    upd_data_we_o = 1'b0;
    upd_data_o    = cpu_wdata_i;
    unique case (state_q)
      PS_IDLE: if (cpu_req_i) begin
        if (local_ok) begin
          cpu_ready_o = 1'b1;
          cpu_rdata_o = line_data_i;
          if (cpu_we_i) begin
            upd_we_o      = 1'b1;
            upd_st_o      = ST_M;
            upd_data_we_o = 1'b1;
          end
        end else begin
          state_d = victim_dirty ? PS_WB : PS_FILL;
        end
      end
      PS_WB: begin
        // a snoop may have taken the victim meanwhile: skip the writeback then
        if (victim_dirty) begin
          bus_req_o   = 1'b1;
          bus_cmd_o   = CMD_WB;
          bus_addr_o  = {line_tag_i, cpu_idx_i};
          bus_wdata_o = line_data_i;
          if (bus_gnt_i) begin
            upd_we_o  = 1'b1;
            upd_st_o  = ST_I;
            upd_tag_o = line_tag_i;
            state_d   = PS_FILL;
          end
        end else begin
          state_d = PS_FILL;
        end
      end
      PS_FILL: begin
        bus_req_o = 1'b1;
        bus_cmd_o = cpu_we_i ? CMD_RDX : CMD_RD;
        if (bus_gnt_i) begin
          cpu_ready_o   = 1'b1;
          cpu_rdata_o   = cpu_we_i ? cpu_wdata_i : bus_rdata_i;
          upd_we_o      = 1'b1;
          upd_st_o      = cpu_we_i ? ST_M : ST_S;
          upd_data_we_o = 1'b1;
          upd_data_o    = cpu_we_i ? cpu_wdata_i : bus_rdata_i;
          state_d       = PS_IDLE;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_IDLE;
    else         state_q <= state_d;
  end

  // R9
  wb_only_modified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == CMD_WB) |-> line_st_i == ST_M);
  // R9
  wb_before_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o != CMD_WB) |-> !(line_st_i == ST_M && line_tag_i != cpu_tag_i));
  // R11
  bus_needs_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> cpu_req_i && bus_cmd_o != CMD_NONE);
  // R4
  hit_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && !bus_gnt_i) |-> !bus_req_o);
endmodule

// File: rtl/msi_wb_ctrl.sv
`timescale 1ns/1ps
module msi_wb_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_gnt_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  line_st_e          c_st, s_st, upd_st, snp_st_new;
  logic [TAG_W-1:0]  c_tag, s_tag, upd_tag;
  logic [DATA_W-1:0] c_data, s_data, upd_data;
  logic              upd_we, upd_data_we, snp_we;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .cpu_idx_i(cpu_idx), .cpu_st_o(c_st), .cpu_tag_o(c_tag), .cpu_data_o(c_data),
    .snp_idx_i(snp_idx), .snp_st_o(s_st), .snp_tag_o(s_tag), .snp_data_o(s_data),
    .upd_we_i(upd_we), .upd_idx_i(cpu_idx), .upd_st_i(upd_st), .upd_tag_i(upd_tag),
    .upd_data_we_i(upd_data_we), .upd_data_i(upd_data),
    .snp_we_i(snp_we), .snp_st_i(snp_st_new)
  );

  msi_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_cmd_i, .snp_tag_i(snp_tag),
    .line_st_i(s_st), .line_tag_i(s_tag), .line_data_i(s_data),
    .flush_o(snp_flush_o), .data_o(snp_data_o),
    .st_we_o(snp_we), .st_o(snp_st_new)
  );

  msi_proc_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_tag_i(cpu_tag), .cpu_idx_i(cpu_idx), .cpu_wdata_i,
    .cpu_ready_o, .cpu_rdata_o,
    .line_st_i(c_st), .line_tag_i(c_tag), .line_data_i(c_data),
    .bus_req_o, .bus_cmd_o, .bus_addr_o, .bus_wdata_o, .bus_gnt_i, .bus_rdata_i,
    .upd_we_o(upd_we), .upd_st_o(upd_st), .upd_tag_o(upd_tag),
    .upd_data_we_o(upd_data_we), .upd_data_o(upd_data)
  );

  // R1
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !bus_req_o);
  // R7
  flush_needs_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> snp_valid_i && (snp_cmd_i == CMD_RD || snp_cmd_i == CMD_RDX));
endmodule

// File: tb/msi_wb_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_wb_ctrl_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SRD = 2'd2, OP_SRDX = 2'd3;
  localparam int NV = 25;
  // {op, addr, wdata, cmd0, cmd1, flush, value, check value, req}
  localparam logic [51:0] VEC [0:NV-1] = '{
    {OP_RD,   8'h04, 16'h0000, 2'd1, 2'd0, 1'b0, 16'h010C, 1'b1, 4'd2},  // R2
    {OP_RD,   8'h04, 16'h0000, 2'd0, 2'd0, 1'b0, 16'h010C, 1'b1, 4'd4},  // R4
    {OP_WR,   8'h04, 16'hA5A5, 2'd2, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd3},  // R3
    {OP_RD,   8'h04, 16'h0000, 2'd0, 2'd0, 1'b0, 16'hA5A5, 1'b1, 4'd4},  // R4
    {OP_WR,   8'h04, 16'h1234, 2'd0, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd4},  // R4
    {OP_SRD,  8'h04, 16'h0000, 2'd0, 2'd0, 1'b1, 16'h1234, 1'b1, 4'd5},  // R5
    {OP_RD,   8'h04, 16'h0000, 2'd0, 2'd0, 1'b0, 16'h1234, 1'b1, 4'd4},  // R4
    {OP_WR,   8'h04, 16'h4321, 2'd2, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd5},  // R5
    {OP_SRD,  8'h04, 16'h0000, 2'd0, 2'd0, 1'b1, 16'h4321, 1'b1, 4'd5},  // R5
    {OP_SRD,  8'h04, 16'h0000, 2'd0, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd6},  // R6
    {OP_SRDX, 8'h04, 16'h0000, 2'd0, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd7},  // R7
    {OP_RD,   8'h04, 16'h0000, 2'd1, 2'd0, 1'b0, 16'h4321, 1'b1, 4'd7},  // R7
    {OP_WR,   8'h05, 16'h5555, 2'd2, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd3},  // R3
    {OP_SRD,  8'h09, 16'h0000, 2'd0, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd8},  // R8
    {OP_RD,   8'h05, 16'h0000, 2'd0, 2'd0, 1'b0, 16'h5555, 1'b1, 4'd8},  // R8
    {OP_RD,   8'h09, 16'h0000, 2'd3, 2'd1, 1'b0, 16'h011B, 1'b1, 4'd9},  // R9
    {OP_RD,   8'h05, 16'h0000, 2'd1, 2'd0, 1'b0, 16'h5555, 1'b1, 4'd10}, // R10
    {OP_WR,   8'h06, 16'h7777, 2'd2, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd3},  // R3
    {OP_SRDX, 8'h06, 16'h0000, 2'd0, 2'd0, 1'b1, 16'h7777, 1'b1, 4'd7},  // R7
    {OP_RD,   8'h06, 16'h0000, 2'd1, 2'd0, 1'b0, 16'h7777, 1'b1, 4'd7},  // R7
    {OP_WR,   8'h0A, 16'h8888, 2'd2, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd10}, // R10
    {OP_WR,   8'h06, 16'h9999, 2'd3, 2'd2, 1'b0, 16'h0000, 1'b0, 4'd9},  // R9
    {OP_RD,   8'h0A, 16'h0000, 2'd3, 2'd1, 1'b0, 16'h8888, 1'b1, 4'd9},  // R9
    {OP_SRD,  8'h0A, 16'h0000, 2'd0, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd6},  // R6
    {OP_RD,   8'h06, 16'h0000, 2'd1, 2'd0, 1'b0, 16'h9999, 1'b1, 4'd10}  // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic bus_gnt = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [AW-1:0] snp_addr = '0;
  logic cpu_ready_o, bus_req_o, snp_flush_o;
  logic [DW-1:0] cpu_rdata_o, bus_wdata_o, snp_data_o;
  logic [1:0] bus_cmd_o;
  logic [AW-1:0] bus_addr_o;

  logic [DW-1:0] mem [0:255];
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  msi_wb_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o, .cpu_rdata_o,
    .bus_req_o, .bus_cmd_o, .bus_addr_o, .bus_wdata_o,
    .bus_gnt_i(bus_gnt), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_flush_o, .snp_data_o
  );

  task automatic check(input int req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [1:0] c0, output logic [1:0] c1, output logic [DW-1:0] rd);
    int n;
    int guard;
    bit done;
    c0 = 2'd0; c1 = 2'd0; rd = '0; n = 0; guard = 0; done = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!done && guard < 40) begin
      if (guard > 0) @(negedge clk);
      bus_gnt = 1'b0;
      guard++;
      #1;
      if (cpu_ready_o) begin
        rd = cpu_rdata_o; done = 1;
      end else if (bus_req_o) begin
        if (n == 0) c0 = bus_cmd_o; else if (n == 1) c1 = bus_cmd_o;
        n++;
        if (bus_cmd_o == 2'd3) mem[bus_addr_o] = bus_wdata_o;
        bus_rdata = mem[bus_addr_o];
        bus_gnt = 1'b1;
        #1;
        if (cpu_ready_o) begin
          rd = cpu_rdata_o; done = 1;
        end
      end
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R2 request to %h never completed: actual 0 expected 1", a);
    end
    @(negedge clk);
    cpu_req = 1'b0; bus_gnt = 1'b0;
  endtask

  task automatic snp_op(input logic [1:0] cmd, input logic [AW-1:0] a,
                        output logic fl, output logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
    #1;
    fl = snp_flush_o; d = snp_data_o;
    if (fl) mem[a] = d;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [1:0] c0, c1;
    logic [DW-1:0] rd, d;
    logic fl;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0100 + 16'(i * 3);

    // R1: reset state
    repeat (2) @(negedge clk);
    check(1, "ready in reset", {15'd0, cpu_ready_o}, 16'd0);
    check(1, "bus_req in reset", {15'd0, bus_req_o}, 16'd0);
    check(1, "flush in reset", {15'd0, snp_flush_o}, 16'd0);
    rst_n = 1'b1;
    // R11: no request, no bus activity
    repeat (3) begin
      @(negedge clk);
      check(11, "bus_req idle", {15'd0, bus_req_o}, 16'd0);
    end
    // R1: all lines Invalid, so a snooped read-exclusive flushes nothing
    for (int k = 0; k < 4; k++) begin
      snp_op(2'd2, 8'(k), fl, d);
      check(1, "flush after reset", {15'd0, fl}, 16'd0);
    end

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op, e0, e1;
      logic [AW-1:0] a;
      logic [DW-1:0] wd, ev;
      logic ef, ec;
      int rq;
      {op, a, wd, e0, e1, ef, ev, ec} = VEC[v][51:4];
      rq = int'(VEC[v][3:0]);
      if (op == OP_RD || op == OP_WR) begin
        cpu_op(op == OP_WR, a, wd, c0, c1, rd);
        check(rq, $sformatf("vec %0d first bus cmd", v), {14'd0, c0}, {14'd0, e0});
        check(rq, $sformatf("vec %0d second bus cmd", v), {14'd0, c1}, {14'd0, e1});
        if (ec) check(rq, $sformatf("vec %0d read data", v), rd, ev);
      end else begin
        snp_op(op == OP_SRD ? 2'd1 : 2'd2, a, fl, d);
        check(rq, $sformatf("vec %0d flush", v), {15'd0, fl}, {15'd0, ef});
        if (ec) check(rq, $sformatf("vec %0d flush data", v), d, ev);
      end
    end

    // R8: unknown snoop codes leave a Modified line alone
    cpu_op(1'b1, 8'h07, 16'hBEEF, c0, c1, rd);
    check(3, "write miss cmd", {14'd0, c0}, 16'd2);
    snp_op(2'd0, 8'h07, fl, d);
    check(8, "code 00 flush", {15'd0, fl}, 16'd0);
    snp_op(2'd3, 8'h07, fl, d);
    check(8, "code 11 flush", {15'd0, fl}, 16'd0);
    snp_op(2'd1, 8'h07, fl, d);
    check(8, "line still Modified", {15'd0, fl}, 16'd1);
    check(5, "flushed word", d, 16'hBEEF);
    // R4: now Shared, a read hits without bus
    cpu_op(1'b0, 8'h07, 16'h0, c0, c1, rd);
    check(4, "read hit no bus", {14'd0, c0}, 16'd0);
    check(4, "read hit data", rd, 16'hBEEF);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule